// File: doc/BRIEF.md
# PHY Bring-Up and Power Sequencer

This block walks a serial-link PHY through its start-up and shutdown steps. It sits on a simple register bus that allows one access at a time. It takes one-cycle commands: initialise, power up the link, power down the link, and shut down. Each command becomes a fixed series of register writes and read-modify-writes, followed by status polls where the command needs them. Every poll has its own millisecond budget. Milliseconds are counted by a prescaler on the system clock. A poll reads the status register once at the start and once after each millisecond tick.

Initialisation turns on the PHY clock enable and programs the PLL dividers. It then powers up the PLL and waits for PLL lock. Link power-up enables the PHY and disables the SE0 drive on resume, then waits first for impedance calibration and then for the link-connect flag. Link power-down clears the enable bit alone. Shutdown powers the PLL down and then drops the clock enable. Each command ends with a one-cycle done pulse and a 2-bit result. A command that arrives while the sequencer is busy is dropped and reported as illegal.

Top module: `phy_seq_ctrl`

## Requirements
- R1: While reset is low and after it is released, busy, done, clk_en, bus_wr and bus_rd are 0 and status is 2'b00.
- R2: An init command (code 0) accepted while idle drives clk_en high in the next cycle. In that same cycle it writes 0x04001AF0 to address 0x1C: bit 26 = 1, bits 17:9 = 0x0D, bits 8:0 = 0xF0.
- R3: After the divider write, init reads address 0x20 and writes it back with bit 10 (PLL power-up) set and every other bit unchanged. At most one of bus_wr and bus_rd is high in any cycle.
- R4: Init then polls address 0x20 until bit 15 (lock) reads 1 and finishes with status 2'b00. Other bits in a status word never count as success.
- R5: A poll with a budget of N ms reads once at its start and once after each millisecond tick, for at most N+1 reads. If the last read misses, the result is status 2'b01. A lock timeout also drops clk_en in the done cycle.
- R6: Power-on (code 1) reads address 0x08 and writes it back with bit 14 cleared and bit 7 set, keeping all other bits.
- R7: Power-on then polls bit 27 of address 0x18 (calibration, CAL_MS budget) and, only after that succeeds, bit 1 of address 0x28 (connect, CONN_MS budget). A miss in either poll gives status 2'b01, and a calibration miss leaves address 0x28 unread.
- R8: Power-off (code 2) clears only bit 7 of address 0x08 and finishes with status 2'b00.
- R9: Exit (code 3) clears only bit 10 of address 0x20, then drops clk_en in the done cycle with status 2'b00.
- R10: done is a single-cycle pulse at the end of every accepted command, and busy is high until then. status changes only in a done cycle or in the cycle after a rejected command. Status codes: 2'b00 ok, 2'b01 timeout, 2'b10 illegal.
- R11: A command received while busy has no effect on the registers or the running sequence. status reads 2'b10 from the next cycle until the running command's done pulse, which reports that command's own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 2 | 0 init, 1 power-on, 2 power-off, 3 exit |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: 00 ok, 01 timeout, 10 illegal |
| clk_en | output | 1 | PHY clock enable |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_wr | output | 1 | Write strobe, single cycle |
| bus_rd | output | 1 | Read strobe, single cycle |
| bus_rdata | input | 32 | Read data |
| bus_rvalid | input | 1 | Read data valid |

## Verification
clk_en and the divider write both appear in the cycle after the edge that accepts init. The bench samples them at the next falling edge. The illegal flag is likewise due one cycle after the rejected strobe. Poll outcomes, read counts and register contents are settled by the done pulse, so the bench waits for done at falling edges and checks status, clk_en and the register model in that cycle. Read counts follow from the millisecond grid: a budget of N allows N+1 reads. The boundary vectors succeed on exactly the last allowed read.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  typedef enum logic [1:0] {
    CMD_INIT    = 2'd0,
    CMD_PWR_ON  = 2'd1,
    CMD_PWR_OFF = 2'd2,
    CMD_EXIT    = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_TMO = 2'd1,
    RES_ILL = 2'd2
  } res_e;

  typedef enum logic [1:0] {
    MOD_PLL_UP   = 2'd0,
    MOD_LINK_EN  = 2'd1,
    MOD_LINK_DIS = 2'd2,
    MOD_PLL_DOWN = 2'd3
  } mod_e;

  typedef enum logic [1:0] {
    PH_LOCK = 2'd0,
    PH_CAL  = 2'd1,
    PH_CONN = 2'd2
  } phase_e;

  localparam logic [REG_AW-1:0] ADR_LINK  = 8'h08;
  localparam logic [REG_AW-1:0] ADR_CAL   = 8'h18;
  localparam logic [REG_AW-1:0] ADR_PLCFG = 8'h1C;
  localparam logic [REG_AW-1:0] ADR_PLPWR = 8'h20;
  localparam logic [REG_AW-1:0] ADR_EVT   = 8'h28;

  localparam int BIT_PLL_UP  = 10;
  localparam int BIT_LOCK    = 15;
  localparam int BIT_LINK_EN = 7;
  localparam int BIT_SE0_RES = 14;
  localparam int BIT_CALDONE = 27;
  localparam int BIT_CONNECT = 1;

  localparam logic [REG_DW-1:0] PLCFG_WORD =
    (REG_DW'(1) << 26) | (REG_DW'(13) << 9) | REG_DW'(240);
endpackage

// File: rtl/phy_seq_tick.sv
module phy_seq_tick #(
  parameter int DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ack,
  output logic tick,
  output logic pend
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          pend_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);
  assign tick = wrap && !clr;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend;
    if (clr) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      cnt_d = wrap ? '0 : cnt_q + CW'(1);
      if (wrap)     pend_d = 1'b1;
      else if (ack) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pend  <= pend_d;
    end
  end
endmodule

// File: rtl/phy_seq_tmo.sv
module phy_seq_tmo #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] elapsed_q;
  logic [TW-1:0] elapsed_d;

  assign expired = (elapsed_q >= limit);

  always_comb begin
    elapsed_d = elapsed_q;
    if (clr)                  elapsed_d = '0;
    else if (tick && !expired) elapsed_d = elapsed_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elapsed_q <= '0;
    else        elapsed_q <= elapsed_d;
  end
endmodule

// File: rtl/phy_seq_mod.sv
module phy_seq_mod
  import phy_seq_pkg::*;
(
  input  mod_e              op,
  input  logic [REG_DW-1:0] din,
  output logic [REG_AW-1:0] addr,
  output logic [REG_DW-1:0] dout
);
  always_comb begin
    dout = din;
    addr = ADR_PLPWR;
    unique case (op)
      MOD_PLL_UP: begin
        dout[BIT_PLL_UP] = 1'b1;
      end
      MOD_LINK_EN: begin
        addr = ADR_LINK;
        dout[BIT_SE0_RES] = 1'b0;
        dout[BIT_LINK_EN] = 1'b1;
      end
      MOD_LINK_DIS: begin
        addr = ADR_LINK;
        dout[BIT_LINK_EN] = 1'b0;
      end
      default: begin
        dout[BIT_PLL_UP] = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 200000,
  parameter int LOCK_MS    = 100,
  parameter int CAL_MS     = 100,
  parameter int CONN_MS    = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_code,
  output logic        busy,
  output logic        done,
  output logic [1:0]  status,
  output logic        clk_en,
  output logic [7:0]  bus_addr,
  output logic [31:0] bus_wdata,
  output logic        bus_wr,
  output logic        bus_rd,
  input  logic [31:0] bus_rdata,
  input  logic        bus_rvalid
);
  localparam int MAX_MS = (LOCK_MS > CAL_MS) ?
                          ((LOCK_MS > CONN_MS) ? LOCK_MS : CONN_MS) :
                          ((CAL_MS > CONN_MS) ? CAL_MS : CONN_MS);
  localparam int TW = $clog2(MAX_MS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CFG_WR, S_RMW_RD, S_RMW_WAIT, S_RMW_WR,
    S_POLL_RD, S_POLL_WAIT, S_POLL_GAP, S_DONE
  } state_e;

  state_e            state_q, state_d;
  mod_e              mod_q, mod_d;
  phase_e            phase_q, phase_d;
  logic [REG_DW-1:0] rmw_q;
  logic [1:0]        status_q, status_d;
  logic              clken_q, clken_d;
  logic              capture;
  logic              poll_start;
  logic              tick_ack;
  logic              tick_pulse;
  logic              tick_pend;
  logic              expired;
  logic [TW-1:0]     limit;
  logic [REG_AW-1:0] mod_addr;
  logic [REG_DW-1:0] mod_data;
  logic [REG_AW-1:0] poll_addr;
  logic [REG_DW-1:0] poll_mask;
  logic              poll_hit;

  phy_seq_tick #(.DIV(CLK_PER_MS)) u_tick (
    .clk (clk), .rst_n (rst_n), .clr (poll_start), .ack (tick_ack),
    .tick (tick_pulse), .pend (tick_pend)
  );

  phy_seq_tmo #(.TW(TW)) u_tmo (
    .clk (clk), .rst_n (rst_n), .clr (poll_start), .tick (tick_pulse),
    .limit (limit), .expired (expired)
  );

  phy_seq_mod u_mod (
    .op (mod_q), .din (rmw_q), .addr (mod_addr), .dout (mod_data)
  );

  always_comb begin
    unique case (phase_q)
      PH_LOCK: begin
        limit = TW'(LOCK_MS); poll_addr = ADR_PLPWR;
        poll_mask = REG_DW'(1) << BIT_LOCK;
      end
      PH_CAL: begin
        limit = TW'(CAL_MS); poll_addr = ADR_CAL;
        poll_mask = REG_DW'(1) << BIT_CALDONE;
      end
      default: begin
        limit = TW'(CONN_MS); poll_addr = ADR_EVT;
        poll_mask = REG_DW'(1) << BIT_CONNECT;
      end
    endcase
  end

  assign poll_hit = ((bus_rdata & poll_mask) == poll_mask);

  always_comb begin
    state_d    = state_q;
    mod_d      = mod_q;
    phase_d    = phase_q;
    status_d   = status_q;
    clken_d    = clken_q;
    capture    = 1'b0;
    poll_start = 1'b0;
    tick_ack   = 1'b0;
    if (cmd_valid && state_q != S_IDLE) status_d = RES_ILL;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          state_d = S_RMW_RD;
          unique case (cmd_e'(cmd_code))
            CMD_INIT: begin
              clken_d = 1'b1;
              state_d = S_CFG_WR;
            end
            CMD_PWR_ON:  mod_d = MOD_LINK_EN;
            CMD_PWR_OFF: mod_d = MOD_LINK_DIS;
            default:     mod_d = MOD_PLL_DOWN;
          endcase
        end
      end
      S_CFG_WR: begin
        mod_d   = MOD_PLL_UP;
        state_d = S_RMW_RD;
      end
      S_RMW_RD: state_d = S_RMW_WAIT;
      S_RMW_WAIT: begin
        if (bus_rvalid) begin
          capture = 1'b1;
          state_d = S_RMW_WR;
        end
      end
      S_RMW_WR: begin
        unique case (mod_q)
          MOD_PLL_UP: begin
            phase_d = PH_LOCK; poll_start = 1'b1; state_d = S_POLL_RD;
          end
          MOD_LINK_EN: begin
            phase_d = PH_CAL; poll_start = 1'b1; state_d = S_POLL_RD;
          end
          MOD_LINK_DIS: begin
            status_d = RES_OK; state_d = S_DONE;
          end
          default: begin
            status_d = RES_OK; clken_d = 1'b0; state_d = S_DONE;
          end
        endcase
      end
      S_POLL_RD: state_d = S_POLL_WAIT;
      S_POLL_WAIT: begin
        if (bus_rvalid) begin
          if (poll_hit) begin
            if (phase_q == PH_CAL) begin
              phase_d = PH_CONN; poll_start = 1'b1; state_d = S_POLL_RD;
            end else begin
              status_d = RES_OK; state_d = S_DONE;
            end
          end else if (expired) begin
            status_d = RES_TMO;
            state_d  = S_DONE;
            if (phase_q == PH_LOCK) clken_d = 1'b0;
          end else begin
            state_d = S_POLL_GAP;
          end
        end
      end
      S_POLL_GAP: begin
        if (tick_pend) begin
          tick_ack = 1'b1;
          state_d  = S_POLL_RD;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      mod_q    <= MOD_PLL_UP;
      phase_q  <= PH_LOCK;
      status_q <= RES_OK;
      clken_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      mod_q    <= mod_d;
      phase_q  <= phase_d;
      status_q <= status_d;
      clken_q  <= clken_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rmw_q <= '0;
    else if (capture) rmw_q <= bus_rdata;
  end

  always_comb begin
    bus_wr    = (state_q == S_CFG_WR) || (state_q == S_RMW_WR);
    bus_rd    = (state_q == S_RMW_RD) || (state_q == S_POLL_RD);
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (state_q)
      S_CFG_WR: begin
        bus_addr  = ADR_PLCFG;
        bus_wdata = PLCFG_WORD;
      end
      S_RMW_RD: bus_addr = mod_addr;
      S_RMW_WR: begin
        bus_addr  = mod_addr;
        bus_wdata = mod_data;
      end
      S_POLL_RD: bus_addr = poll_addr;
      default: ;
    endcase
  end

  assign busy   = (state_q != S_IDLE);
  assign done   = (state_q == S_DONE);
  assign status = status_q;
  assign clk_en = clken_q;
endmodule

// File: rtl/phy_seq_ctrl_chk.sv
module phy_seq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [1:0]  cmd_code,
  input logic        busy,
  input logic        done,
  input logic [1:0]  status,
  input logic        clk_en,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata
);
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_wr || bus_rd)); // R1

  AST_CLKEN_RISE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(cmd_valid && !busy && cmd_code == 2'd0)); // R2

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> (bus_wr && bus_addr == 8'h1C && bus_wdata == 32'h0400_1AF0)); // R2

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R3

  AST_CLKEN_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> done); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R10

  AST_STATUS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> (done || $past(cmd_valid && busy))); // R10

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && !done) |=> (status == 2'b10 || done)); // R11
endmodule

bind phy_seq_ctrl phy_seq_ctrl_chk u_chk (
  .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_code (cmd_code),
  .busy (busy), .done (done), .status (status), .clk_en (clk_en),
  .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/phy_seq_ctrl_bench.sv
module phy_seq_ctrl_bench;
  localparam int CPM  = 8;
  localparam int LOCK = 3;
  localparam int CAL  = 3;
  localparam int CONN = 5;
  localparam logic [31:0] LINK_INIT = 32'h0000_4A25;
  localparam logic [31:0] PWR_INIT  = 32'h0012_0301;

  typedef struct packed {
    logic [1:0]  cmd;
    logic [7:0]  ld, cd, nd;
    logic [1:0]  st;
    logic        ce;
    logic [7:0]  lr, cr, nr;
    logic [15:0] link;
    logic        pu;
  } vec_t;

  localparam vec_t VEC [0:10] = '{
    '{2'd0, 8'd2,   8'd0,   8'd0,   2'd0, 1'b1, 8'd3, 8'd0, 8'd0, 16'h4A25, 1'b1},
    '{2'd1, 8'd0,   8'd1,   8'd2,   2'd0, 1'b1, 8'd0, 8'd2, 8'd3, 16'h0AA5, 1'b1},
    '{2'd2, 8'd0,   8'd0,   8'd0,   2'd0, 1'b1, 8'd0, 8'd0, 8'd0, 16'h0A25, 1'b1},
    '{2'd3, 8'd0,   8'd0,   8'd0,   2'd0, 1'b0, 8'd1, 8'd0, 8'd0, 16'h0A25, 1'b0},
    '{2'd0, 8'd255, 8'd0,   8'd0,   2'd1, 1'b0, 8'd4, 8'd0, 8'd0, 16'h0A25, 1'b1},
    '{2'd3, 8'd0,   8'd0,   8'd0,   2'd0, 1'b0, 8'd1, 8'd0, 8'd0, 16'h0A25, 1'b0},
    '{2'd0, 8'd3,   8'd0,   8'd0,   2'd0, 1'b1, 8'd4, 8'd0, 8'd0, 16'h0A25, 1'b1},
    '{2'd1, 8'd0,   8'd255, 8'd0,   2'd1, 1'b1, 8'd0, 8'd4, 8'd0, 16'h0AA5, 1'b1},
    '{2'd1, 8'd0,   8'd0,   8'd255, 2'd1, 1'b1, 8'd0, 8'd1, 8'd6, 16'h0AA5, 1'b1},
    '{2'd1, 8'd0,   8'd3,   8'd5,   2'd0, 1'b1, 8'd0, 8'd4, 8'd6, 16'h0AA5, 1'b1},
    '{2'd3, 8'd0,   8'd0,   8'd0,   2'd0, 1'b0, 8'd1, 8'd0, 8'd0, 16'h0AA5, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic        busy, done, clk_en, bus_wr, bus_rd, bus_rvalid;
  logic [1:0]  status;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  logic [31:0] m_link, m_pwr, m_cfg;
  int n_lock, n_cal, n_conn;
  int b_lock, b_cal, b_conn;
  int lock_dly, cal_dly, conn_dly;
  int n_cmp, n_bad;
  bit finished;

  phy_seq_ctrl #(.CLK_PER_MS(CPM), .LOCK_MS(LOCK), .CAL_MS(CAL), .CONN_MS(CONN))
  u_phy_seq_ctrl (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_code (cmd_code),
    .busy (busy), .done (done), .status (status), .clk_en (clk_en),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural PHY register model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_link <= LINK_INIT; m_pwr <= PWR_INIT; m_cfg <= '0;
      bus_rvalid <= 1'b0; bus_rdata <= '0;
      n_lock <= 0; n_cal <= 0; n_conn <= 0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          8'h08: bus_rdata <= m_link;
          8'h1C: bus_rdata <= m_cfg;
          8'h18: begin
            bus_rdata <= 32'h0000_0C00 | ((n_cal - b_cal >= cal_dly) ? 32'h0800_0000 : 32'h0);
            n_cal <= n_cal + 1;
          end
          8'h20: begin
            bus_rdata <= m_pwr | ((m_pwr[10] && (n_lock - b_lock >= lock_dly)) ? 32'h8000 : 32'h0);
            if (m_pwr[10]) n_lock <= n_lock + 1;
          end
          8'h28: begin
            bus_rdata <= 32'h0000_0004 | ((n_conn - b_conn >= conn_dly) ? 32'h2 : 32'h0);
            n_conn <= n_conn + 1;
          end
          default: bus_rdata <= '0;
        endcase
      end
      if (bus_wr) begin
        case (bus_addr)
          8'h08: m_link <= bus_wdata;
          8'h1C: m_cfg  <= bus_wdata;
          8'h20: m_pwr  <= bus_wdata & ~32'h8000;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic issue(input logic [1:0] code, input int ld, input int cd, input int nd);
    @(negedge clk);
    b_lock = n_lock; b_cal = n_cal; b_conn = n_conn;
    lock_dly = ld; cal_dly = cd; conn_dly = nd;
    cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(done, req, "done pulse seen", {31'd0, done}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; finished = 0;
    cmd_valid = 1'b0; cmd_code = 2'd0;
    b_lock = 0; b_cal = 0; b_conn = 0;
    lock_dly = 0; cal_dly = 0; conn_dly = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !clk_en && !bus_wr && !bus_rd && status == 2'd0,
        "R1", "outputs in reset", {busy, done, clk_en, bus_wr, bus_rd, status}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !clk_en && status == 2'd0, "R1", "outputs after reset",
        {busy, done, clk_en, status}, 32'd0);

    // directed: clock enable and divider write one cycle after init
    issue(2'd0, 0, 0, 0);
    chk(clk_en == 1'b1, "R2", "clk_en after init", {31'd0, clk_en}, 32'd1);
    chk(bus_wr && bus_addr == 8'h1C, "R2", "cfg write address", {23'd0, bus_wr, bus_addr}, 32'h11C);
    chk(bus_wdata == 32'h0400_1AF0, "R2", "cfg write data", bus_wdata, 32'h0400_1AF0);
    wait_done("R4");
    chk(status == 2'd0, "R4", "immediate lock status", {30'd0, status}, 32'd0);
    chk(m_cfg == 32'h0400_1AF0, "R2", "cfg register", m_cfg, 32'h0400_1AF0);
    chk(m_pwr == (PWR_INIT | 32'h400), "R3", "pll power-up rmw", m_pwr, PWR_INIT | 32'h400);
    @(negedge clk);
    chk(!done, "R10", "done single cycle", {31'd0, done}, 32'd0);
    issue(2'd3, 0, 0, 0);
    wait_done("R9");
    chk(m_pwr == PWR_INIT && clk_en == 1'b0, "R9", "exit restores power reg",
        m_pwr, PWR_INIT);

    // table of command vectors
    for (int i = 0; i < 11; i++) begin
      vec_t v;
      v = VEC[i];
      issue(v.cmd, int'(v.ld), int'(v.cd), int'(v.nd));
      wait_done("R10");
      chk(status == v.st, "R5 R7 R10", $sformatf("vec %0d status", i), {30'd0, status}, {30'd0, v.st});
      chk(clk_en == v.ce, "R5 R9", $sformatf("vec %0d clk_en", i), {31'd0, clk_en}, {31'd0, v.ce});
      chk(n_lock - b_lock == int'(v.lr), "R4 R5", $sformatf("vec %0d lock reads", i),
          32'(n_lock - b_lock), {24'd0, v.lr});
      chk(n_cal - b_cal == int'(v.cr), "R7", $sformatf("vec %0d cal reads", i),
          32'(n_cal - b_cal), {24'd0, v.cr});
      chk(n_conn - b_conn == int'(v.nr), "R7", $sformatf("vec %0d connect reads", i),
          32'(n_conn - b_conn), {24'd0, v.nr});
      chk(m_link == {16'd0, v.link}, "R6 R8", $sformatf("vec %0d link reg", i),
          m_link, {16'd0, v.link});
      chk(m_pwr == (v.pu ? (PWR_INIT | 32'h400) : PWR_INIT), "R3 R9",
          $sformatf("vec %0d power reg", i), m_pwr, v.pu ? (PWR_INIT | 32'h400) : PWR_INIT);
    end

    // directed: command while busy is dropped and flagged
    issue(2'd0, 2, 0, 0);
    cmd_valid = 1'b1; cmd_code = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(status == 2'd2 && busy, "R11", "illegal flag while busy", {30'd0, status}, 32'd2);
    wait_done("R11");
    chk(status == 2'd0 && clk_en, "R11", "running init result", {30'd0, status}, 32'd0);
    chk(m_link == 32'h0000_0AA5, "R11", "link reg untouched by dropped command",
        m_link, 32'h0000_0AA5);
    @(negedge clk);
    chk(!busy && !done, "R10", "idle after done", {30'd0, busy, done}, 32'd0);

    finished = 1;
    summary();
    $finish;
  end
endmodule